// File: doc/BRIEF.md
# Pulse-Width Coded Serial Bit Receiver

This block receives a slow, one-way debug stream on a single wire. The stream has no clock line. Each bit opens with a rising edge. The value of the bit is carried by how long the line then stays high: a short high pulse means 0 and a long high pulse means 1. Both kinds of bit take the same total time.

The receiver first synchronises the line to its own clock. Each rising edge starts a delay counter. When the counter expires, the receiver samples the line once and shifts that bit into a word. Because every bit brings its own timing reference, the receiver needs no baud-rate generator. The only timing constant is the sample delay, which must fall between the short and the long pulse widths.

A complete word is presented with a one-cycle strobe. Its low nibble is decoded for a hexadecimal 7-segment digit, so the debugged system's state can be shown on a display. If a new edge arrives before the previous bit has been sampled, a protocol-error strobe is raised. If a partial word stalls, it is dropped after a timeout.

Top module: `pwc_bit_rx`

## Requirements
- R1: A rising edge on `line_i`, seen after a two-flop synchroniser, starts a bit. The line is sampled SAMPLE_DLY cycles later. A high sample gives bit value 1 and a low sample gives 0.
- R2: With `lsb_first_i` = 0, the first bit received of a word lands in `word_o[WORD_BITS-1]` and the last one in `word_o[0]`.
- R3: With `lsb_first_i` = 1, the first bit received lands in `word_o[0]` and the last one in `word_o[WORD_BITS-1]`. The input is held constant for the length of a word.
- R4: After WORD_BITS sampled bits, `word_o` takes the new word and `word_valid_o` is high for exactly one cycle. `word_o` then holds until the next complete word.
- R5: A rising edge that arrives while the previous bit is still waiting for its sample point raises `proto_err_o` for one cycle. It also discards the partial word. The same edge then starts the first bit of a new word. An edge in the very cycle of the sample point is not an error.
- R6: If a partial word sees no rising edge for FRAME_TIMEOUT cycles, its bits are discarded. The next edge starts a new word, and no `word_valid_o` is raised for the dropped bits.
- R7: `seg_o` shows the low nibble of the last valid word as a hex digit, active high. Bit 0 is segment a, through bit 6, which is segment g. The codes are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F A:77 b:7C C:39 d:5E E:79 F:71. The digit holds until the next valid word.
- R8: After reset, `word_valid_o` and `proto_err_o` are 0, `word_o` is 0, and `seg_o` is 0 (all segments off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| line_i | input | 1 | Asynchronous serial debug line |
| lsb_first_i | input | 1 | Bit order select: 0 most significant first, 1 least significant first |
| word_o | output | WORD_BITS | Last complete word |
| word_valid_o | output | 1 | One-cycle strobe when `word_o` is updated |
| proto_err_o | output | 1 | One-cycle strobe on an edge before the sample point |
| seg_o | output | 7 | Active-high 7-segment pattern, bit 0 = a ... bit 6 = g |

## Verification
The bench builds the block with WORD_BITS = 8, SAMPLE_DLY = 12 and FRAME_TIMEOUT = 100. With these values a narrow pulse of 6 cycles, a wide pulse of 24 cycles and a 36-cycle bit period all fit well inside a short run. A stalled partial word times out within a few bit periods, so many random words in both bit orders can be checked. The error case is reached by placing a second edge a few cycles after the first, well before the 12-cycle sample point. The timeout case is reached by stopping a word after three bits and waiting past 100 cycles.

// File: rtl/pwc_rx_pkg.sv
package pwc_rx_pkg;

  // Active-high 7-segment pattern, bit 0 = segment a ... bit 6 = segment g.
  function automatic logic [6:0] hex_to_seg(input logic [3:0] nib);
    logic [6:0] s;
    case (nib)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pwc_line_sync.sv
module pwc_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], line_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;

  // R1: an edge pulse lasts one cycle only.
  p_rise_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pwc_bit_sampler.sv
module pwc_bit_sampler #(
  parameter int unsigned SAMPLE_DLY = 750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic level_i,
  output logic bit_stb_o,
  output logic bit_o,
  output logic abort_o,
  output logic err_o
);
  localparam int unsigned CW = (SAMPLE_DLY > 1) ? $clog2(SAMPLE_DLY) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(SAMPLE_DLY - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          at_sample;

  assign at_sample = busy_q && (cnt_q == '0);
  assign abort_o   = rise_i && busy_q && (cnt_q != '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    err_d  = abort_o;
    if (rise_i) begin
      busy_d = 1'b1;
      cnt_d  = RELOAD;
    end else if (at_sample) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      err_q  <= err_d;
    end
  end

  assign bit_stb_o = at_sample;
  assign bit_o     = level_i;
  assign err_o     = err_q;

  // R1: waiting for a sample only ever begins on an edge.
  p_busy_from_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(rise_i));
  // R5: the error strobe is a single cycle.
  p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);
endmodule

// File: rtl/pwc_word_asm.sv
module pwc_word_asm #(
  parameter int unsigned WORD_BITS     = 8,
  parameter int unsigned FRAME_TIMEOUT = 5000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rise_i,
  input  logic                 bit_stb_i,
  input  logic                 bit_i,
  input  logic                 abort_i,
  input  logic                 lsb_first_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 valid_o
);
  localparam int unsigned BW = $clog2(WORD_BITS);
  localparam int unsigned TW = $clog2(FRAME_TIMEOUT + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_BITS - 1);
  localparam logic [TW-1:0] TO_LAST  = TW'(FRAME_TIMEOUT - 1);

  logic [WORD_BITS-1:0] sh_q, sh_d, shifted;
  logic [BW-1:0]        nb_q, nb_d;
  logic [TW-1:0]        idle_q, idle_d;
  logic [WORD_BITS-1:0] word_q, word_d;
  logic                 valid_q, valid_d;
  logic                 partial;

  assign partial = (nb_q != '0);
  assign shifted = lsb_first_i ? {bit_i, sh_q[WORD_BITS-1:1]}
                               : {sh_q[WORD_BITS-2:0], bit_i};

  always_comb begin
    sh_d    = sh_q;
    nb_d    = nb_q;
    idle_d  = idle_q;
    word_d  = word_q;
    valid_d = 1'b0;
    if (rise_i || !partial) begin
      idle_d = '0;
    end else begin
      idle_d = idle_q + 1'b1;
    end
    if (bit_stb_i) begin
      sh_d = shifted;
      if (nb_q == LAST_BIT) begin
        nb_d    = '0;
        word_d  = shifted;
        valid_d = 1'b1;
      end else begin
        nb_d = nb_q + 1'b1;
      end
    end else if (abort_i) begin
      nb_d = '0;
    end else if (partial && !rise_i && idle_q == TO_LAST) begin
      nb_d   = '0;
      idle_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      nb_q    <= '0;
      idle_q  <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      nb_q    <= nb_d;
      idle_q  <= idle_d;
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  // R4: valid is a one-cycle strobe.
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R4: the word holds between strobes.
  p_word_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_d |=> $stable(word_o));
  // R6: the idle counter never passes the timeout.
  p_idle_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q < TW'(FRAME_TIMEOUT));
  // R4: the bit count stays inside the word.
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nb_q <= LAST_BIT);
endmodule

// File: rtl/pwc_hex_seg.sv
module pwc_hex_seg
  import pwc_rx_pkg::*;
#(
  parameter int unsigned WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [WORD_BITS-1:0] word_i,
  output logic [6:0]           seg_o
);
  logic [6:0] seg_q, seg_d;

  always_comb begin
    seg_d = seg_q;
    if (load_i) seg_d = hex_to_seg(word_i[3:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seg_q <= '0;
    else        seg_q <= seg_d;
  end

  assign seg_o = seg_q;

  // R7: the display changes only after a valid word.
  p_seg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(seg_o));
endmodule

// File: rtl/pwc_bit_rx.sv
module pwc_bit_rx #(
  parameter int unsigned WORD_BITS     = 8,
  parameter int unsigned SAMPLE_DLY    = 750,
  parameter int unsigned FRAME_TIMEOUT = 5000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_i,
  input  logic                 lsb_first_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 word_valid_o,
  output logic                 proto_err_o,
  output logic [6:0]           seg_o
);
  logic level, rise, bit_stb, bit_val, abort;

  pwc_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(line_i),
    .level_o(level), .rise_o(rise)
  );

  pwc_bit_sampler #(.SAMPLE_DLY(SAMPLE_DLY)) u_samp (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .level_i(level),
    .bit_stb_o(bit_stb), .bit_o(bit_val), .abort_o(abort), .err_o(proto_err_o)
  );

  pwc_word_asm #(.WORD_BITS(WORD_BITS), .FRAME_TIMEOUT(FRAME_TIMEOUT)) u_asm (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .bit_stb_i(bit_stb),
    .bit_i(bit_val), .abort_i(abort), .lsb_first_i(lsb_first_i),
    .word_o(word_o), .valid_o(word_valid_o)
  );

  pwc_hex_seg #(.WORD_BITS(WORD_BITS)) u_seg (
    .clk(clk), .rst_n(rst_n), .load_i(word_valid_o),
    .word_i(word_o), .seg_o(seg_o)
  );

  // R5: an error and a completed word never appear together.
  p_err_not_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |-> !word_valid_o);
endmodule

// File: tb/test_pwc_bit_rx.sv
module test_pwc_bit_rx;
  localparam int NB = 8, DLY = 12, TO = 100;
  localparam int NARROW = 6, WIDE = 24, PERIOD = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_i = 1'b0;
  logic lsb_first_i = 1'b0;
  logic [NB-1:0] word_o;
  logic word_valid_o, proto_err_o;
  logic [6:0] seg_o;

  int checks = 0, fails = 0;
  int n_valid = 0, n_err = 0;
  logic [NB-1:0] last_word = '0;
  bit done = 0;

  always #2 clk = ~clk;

  pwc_bit_rx #(.WORD_BITS(NB), .SAMPLE_DLY(DLY), .FRAME_TIMEOUT(TO)) i_pwc_bit_rx (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .lsb_first_i(lsb_first_i),
    .word_o(word_o), .word_valid_o(word_valid_o), .proto_err_o(proto_err_o),
    .seg_o(seg_o)
  );

  always @(negedge clk) begin
    if (rst_n && word_valid_o) begin n_valid++; last_word = word_o; end
    if (rst_n && proto_err_o) n_err++;
  end

  function automatic logic [6:0] exp_seg(input logic [3:0] n);
    logic [6:0] t [16] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,
                           7'h7F,7'h6F,7'h77,7'h7C,7'h39,7'h5E,7'h79,7'h71};
    return t[n];
  endfunction

  function automatic logic [NB-1:0] rev(input logic [NB-1:0] w);
    logic [NB-1:0] r;
    for (int i = 0; i < NB; i++) r[i] = w[NB-1-i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bit(input logic b);
    line_i = 1'b1;
    wait_cyc(b ? WIDE : NARROW);
    line_i = 1'b0;
    wait_cyc(PERIOD - (b ? WIDE : NARROW));
  endtask

  // Transmits the word in the order chosen by lsb.
  task automatic send_word(input logic [NB-1:0] w, input logic lsb);
    for (int i = 0; i < NB; i++) send_bit(lsb ? w[i] : w[NB-1-i]);
  endtask

  task automatic word_test(input string req, input logic [NB-1:0] w, input logic lsb);
    int v0;
    lsb_first_i = lsb;
    v0 = n_valid;
    send_word(w, lsb);
    wait_cyc(DLY + 8);
    @(negedge clk);
    check({req, " valid count"}, n_valid, v0 + 1);
    check({req, " word"}, last_word, w);
    check("R7 seg", seg_o, exp_seg(w[3:0]));
  endtask

  initial begin
    int e0, v0;
    logic [NB-1:0] w;
    void'($urandom(32'd1234));
    wait_cyc(3);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(2);
    @(negedge clk);
    check("R8 valid", word_valid_o, 0);
    check("R8 err", proto_err_o, 0);
    check("R8 word", word_o, 0);
    check("R8 seg", seg_o, 0);

    word_test("R1 R2 zeros", 8'h00, 1'b0);
    word_test("R1 R2 ones", 8'hFF, 1'b0);
    word_test("R2 msb", 8'hA5, 1'b0);
    word_test("R3 lsb", 8'h3C, 1'b1);
    // R3: same bit sequence, opposite order, gives the reversed word
    lsb_first_i = 1'b1;
    send_word(rev(8'hA5), 1'b0);
    wait_cyc(DLY + 8);
    @(negedge clk);
    check("R3 order", last_word, 8'hA5);

    // R7: the digit holds while nothing completes
    wait_cyc(50);
    @(negedge clk);
    check("R7 hold", seg_o, exp_seg(4'h5));

    // R6: a stalled partial word is dropped
    lsb_first_i = 1'b0;
    v0 = n_valid;
    send_bit(1); send_bit(0); send_bit(1);
    wait_cyc(TO + 40);
    @(negedge clk);
    check("R6 no valid on drop", n_valid, v0);
    word_test("R6 after timeout", 8'h96, 1'b0);

    // R5: an early edge flags an error and restarts the word
    e0 = n_err;
    line_i = 1'b1; wait_cyc(2); line_i = 1'b0; wait_cyc(3);
    word_test("R5 restart", 8'h4B, 1'b0);
    check("R5 err count", n_err, e0 + 1);

    // R5: a partial word before the glitch is discarded
    e0 = n_err;
    send_bit(1); send_bit(1);
    line_i = 1'b1; wait_cyc(2); line_i = 1'b0; wait_cyc(3);
    word_test("R5 discard", 8'h17, 1'b0);
    check("R5 err count 2", n_err, e0 + 1);

    for (int k = 0; k < 24; k++) begin
      w = NB'($urandom);
      word_test((k % 2) ? "R3 rand" : "R2 rand", w, 1'(k % 2));
    end
    check("R5 no spurious err", n_err, 2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule